// File: doc/BRIEF.md
# Per-Pin Configurable Interrupt Detector

This block turns a group of already synchronised input pins into interrupt status and one combined interrupt line. Each pin is set up on its own. It can detect a level or an edge. In edge mode it can detect one edge or both edges. A polarity bit chooses the high level or rising edge, or else the low level or falling edge.

An edge sets a per-pin status bit that stays set until software writes a one to that bit of the clear register. A level-mode pin shows its status directly from the pin, so the status drops on its own when the pin leaves the active level. An enable mask gates the raw status into a masked status. The interrupt output is the OR of all masked bits.

Software reaches the block through a simple byte-wide register port. Writes take effect on the next clock edge. The read data is a combinational function of the address.

Top module: `irq_detect`

## Requirements
- R1: After reset, the sense, both-edges, polarity and enable registers and every edge status bit read 0, and `irq_o` is 0.
- R2: The configuration registers read back the last value written. Their addresses are: sense (1 = level, 0 = edge) at address 0, both-edges at 1, polarity at 2, enable (1 = enabled) at 3. Raw status is at 4, masked status at 5, and clear at 6. The bit index equals the pin index.
- R3: For an edge-mode pin with both-edges 0 and polarity 1, a 0-to-1 change on the pin sets its raw status bit in the cycle after the clock edge that samples the new value. A 1-to-0 change does not set it.
- R4: For an edge-mode pin with both-edges 0 and polarity 0, a 1-to-0 change sets its raw status bit and a 0-to-1 change does not.
- R5: For an edge-mode pin with both-edges 1, both a rising and a falling change set the status bit, whatever its polarity bit holds.
- R6: For a level-mode pin, the raw status bit equals 1 exactly while the pin equals its polarity bit. It clears by itself with no clear write, and the both-edges bit has no effect on it.
- R7: Writing 1 to bit n of the clear register clears the latched edge status of pin n. Writing 0 leaves it unchanged. A clear write has no effect on a level-mode pin's status.
- R8: When an edge is detected on a pin in the same cycle as a clear write to that pin, the status bit ends up set.
- R9: Changing a pin between edge and level mode does not clear its latched edge status, and edges seen while a pin is in level mode are not latched.
- R10: The masked status register reads as raw status AND enable. Writes to the raw and masked status addresses change nothing.
- R11: `irq_o` is 1 exactly when at least one masked status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | N_PINS | Synchronised pin levels |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | N_PINS | Write data |
| bus_rdata_o | output | N_PINS | Read data for the addressed register |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest state to reach from the ports is a collision: a clear write and a fresh edge on the same pin in one clock. The bench reaches it by driving the pin transition and the clear write together on the same falling clock edge, so that the next rising edge sees both at once. Another hard case is an edge latch kept hidden behind level mode. The bench latches an edge, switches the pin to level mode with the pin away from its active level, and returns the pin to edge mode to show that the bit reappears.

// File: rtl/irq_detect_pkg.sv
package irq_detect_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_SENSE  = 3'd0,
    REG_BOTH   = 3'd1,
    REG_POL    = 3'd2,
    REG_EN     = 3'd3,
    REG_RAW    = 3'd4,
    REG_MASKED = 3'd5,
    REG_CLEAR  = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/irq_edge_detect.sv
// Delays the pin vector by one cycle and reports qualified edge events.
module irq_edge_detect #(
  parameter int N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin,
  input  logic [N_PINS-1:0] sense,
  input  logic [N_PINS-1:0] both,
  input  logic [N_PINS-1:0] pol,
  output logic [N_PINS-1:0] evt
);
  logic [N_PINS-1:0] prev_q, prev_d;
  logic [N_PINS-1:0] rise, fall;

  always_comb begin
    prev_d = pin;
    rise   = pin & ~prev_q;
    fall   = ~pin & prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_evt
    always_comb begin
      if (sense[i])     evt[i] = 1'b0;
      else if (both[i]) evt[i] = rise[i] | fall[i];
      else if (pol[i])  evt[i] = rise[i];
      else              evt[i] = fall[i];
    end
  end
endmodule

// File: rtl/irq_pin_cell.sv
// One pin: edge latch with set-over-clear, and raw status selection.
module irq_pin_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic sense,
  input  logic pol,
  input  logic evt,
  input  logic clr,
  output logic latch,
  output logic raw
);
  logic latch_d;
  logic level_hit;

  always_comb begin
    latch_d = latch;
    if (clr) latch_d = 1'b0;
    if (evt) latch_d = 1'b1;
    level_hit = (pin == pol);
    raw       = sense ? level_hit : latch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch <= 1'b0;
    else        latch <= latch_d;
  end
endmodule

// File: rtl/irq_regfile.sv
// Configuration registers, clear pulse decode and read multiplexer.
module irq_regfile
  import irq_detect_pkg::*;
#(
  parameter int N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_PINS-1:0] wdata,
  input  logic [N_PINS-1:0] raw,
  input  logic [N_PINS-1:0] masked,
  output logic [N_PINS-1:0] sense,
  output logic [N_PINS-1:0] both,
  output logic [N_PINS-1:0] pol,
  output logic [N_PINS-1:0] en,
  output logic [N_PINS-1:0] clr,
  output logic [N_PINS-1:0] rdata
);
  logic [N_PINS-1:0] sense_d, both_d, pol_d, en_d;
  logic sense_we, both_we, pol_we, en_we;

  always_comb begin
    sense_we = wr && (addr == REG_SENSE);
    both_we  = wr && (addr == REG_BOTH);
    pol_we   = wr && (addr == REG_POL);
    en_we    = wr && (addr == REG_EN);
    sense_d  = sense_we ? wdata : sense;
    both_d   = both_we  ? wdata : both;
    pol_d    = pol_we   ? wdata : pol;
    en_d     = en_we    ? wdata : en;
    clr      = (wr && (addr == REG_CLEAR)) ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense <= '0;
      both  <= '0;
      pol   <= '0;
      en    <= '0;
    end else begin
      sense <= sense_d;
      both  <= both_d;
      pol   <= pol_d;
      en    <= en_d;
    end
  end

  always_comb begin
    case (addr)
      REG_SENSE:  rdata = sense;
      REG_BOTH:   rdata = both;
      REG_POL:    rdata = pol;
      REG_EN:     rdata = en;
      REG_RAW:    rdata = raw;
      REG_MASKED: rdata = masked;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_detect.sv
module irq_detect
  import irq_detect_pkg::*;
#(
  parameter int N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [N_PINS-1:0] bus_wdata_i,
  output logic [N_PINS-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] sense_q, both_q, pol_q, en_q;
  logic [N_PINS-1:0] clr_vec, edge_evt, edge_latch, raw_status, masked_status;

  irq_regfile #(.N_PINS(N_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr(bus_wr_i), .addr(bus_addr_i), .wdata(bus_wdata_i),
    .raw(raw_status), .masked(masked_status),
    .sense(sense_q), .both(both_q), .pol(pol_q), .en(en_q),
    .clr(clr_vec), .rdata(bus_rdata_o)
  );

  irq_edge_detect #(.N_PINS(N_PINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(pin_i),
    .sense(sense_q), .both(both_q), .pol(pol_q), .evt(edge_evt)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    irq_pin_cell u_cell (
      .clk(clk), .rst_n(rst_n), .pin(pin_i[i]),
      .sense(sense_q[i]), .pol(pol_q[i]),
      .evt(edge_evt[i]), .clr(clr_vec[i]),
      .latch(edge_latch[i]), .raw(raw_status[i])
    );
  end

  always_comb begin
    masked_status = raw_status & en_q;
    irq_o         = |masked_status;
  end
endmodule

// File: rtl/irq_detect_chk.sv
module irq_detect_chk #(
  parameter int N_PINS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic [N_PINS-1:0] en,
  input logic [N_PINS-1:0] sense,
  input logic [N_PINS-1:0] evt,
  input logic [N_PINS-1:0] clr,
  input logic [N_PINS-1:0] latch
);
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq); // R11

  AST_NO_LATCH_IN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ((latch & ~$past(latch) & $past(sense)) == '0)); // R9

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(clr) & ~$past(evt) & latch) == '0)); // R7

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((~latch & $past(latch) & ~$past(clr)) == '0)); // R9

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(evt) & ~latch) == '0)); // R8
endmodule

bind irq_detect irq_detect_chk #(.N_PINS(N_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq_o), .en(en_q), .sense(sense_q),
  .evt(edge_evt), .clr(clr_vec), .latch(edge_latch)
);

// File: tb/irq_detect_test.sv
module irq_detect_test;
  import irq_detect_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = '0;
  logic       wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_detect #(.N_PINS(8)) uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic drive(input logic [7:0] v);
    @(negedge clk);
    pins = v;
    @(negedge clk);
  endtask

  task automatic clean();
    drive(8'h00);
    drive(8'h00);
    wreg(REG_SENSE, 8'h00);
    wreg(REG_BOTH, 8'h00);
    wreg(REG_POL, 8'h00);
    wreg(REG_EN, 8'h00);
    wreg(REG_CLEAR, 8'hFF);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 6; a++) begin
      rreg(3'(a), v);
      check("R1 reset register", v, 8'h00);
    end
    check("R1 reset irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wreg(REG_SENSE, 8'hA5); wreg(REG_BOTH, 8'h3C);
    wreg(REG_POL, 8'h96);   wreg(REG_EN, 8'h00);
    rreg(REG_SENSE, v); check("R2 sense readback", v, 8'hA5);
    rreg(REG_BOTH, v);  check("R2 both readback", v, 8'h3C);
    rreg(REG_POL, v);   check("R2 pol readback", v, 8'h96);
    wreg(REG_EN, 8'h5A);
    rreg(REG_EN, v);    check("R2 enable readback", v, 8'h5A);
    clean();
  endtask

  task automatic t_rise();
    logic [7:0] v;
    wreg(REG_POL, 8'h01);
    drive(8'h01);
    rreg(REG_RAW, v); check("R3 rising latched", v, 8'h01);
    wreg(REG_CLEAR, 8'h01);
    drive(8'h00);
    rreg(REG_RAW, v); check("R3 falling ignored", v, 8'h00);
    clean();
  endtask

  task automatic t_fall();
    logic [7:0] v;
    drive(8'h02);
    rreg(REG_RAW, v); check("R4 rising ignored", v, 8'h00);
    drive(8'h00);
    rreg(REG_RAW, v); check("R4 falling latched", v, 8'h02);
    clean();
  endtask

  task automatic t_both();
    logic [7:0] v;
    wreg(REG_BOTH, 8'h0C); wreg(REG_POL, 8'h04);
    drive(8'h0C);
    rreg(REG_RAW, v); check("R5 both rising", v, 8'h0C);
    wreg(REG_CLEAR, 8'h0C);
    drive(8'h00);
    rreg(REG_RAW, v); check("R5 both falling", v, 8'h0C);
    clean();
  endtask

  task automatic t_level();
    logic [7:0] v;
    wreg(REG_SENSE, 8'h18); wreg(REG_BOTH, 8'h08); wreg(REG_POL, 8'h08);
    rreg(REG_RAW, v); check("R6 low pin active-low", v, 8'h10);
    @(negedge clk); pins = 8'h18; addr = REG_RAW;
    #1 check("R6 level follows pin", rdata, 8'h08);
    @(negedge clk); pins = 8'h00;
    #1 check("R6 level self-clears", rdata, 8'h10);
    clean();
  endtask

  task automatic t_clear();
    logic [7:0] v;
    wreg(REG_POL, 8'h0B); wreg(REG_SENSE, 8'h08);
    drive(8'h0B);
    rreg(REG_RAW, v); check("R7 setup", v, 8'h0B);
    wreg(REG_CLEAR, 8'h00);
    rreg(REG_RAW, v); check("R7 zero write no effect", v, 8'h0B);
    wreg(REG_CLEAR, 8'h01);
    rreg(REG_RAW, v); check("R7 clear one bit", v, 8'h0A);
    wreg(REG_CLEAR, 8'h08);
    rreg(REG_RAW, v); check("R7 level pin unaffected", v, 8'h0A);
    clean();
  endtask

  task automatic t_priority();
    logic [7:0] v;
    wreg(REG_POL, 8'h01);
    @(negedge clk);
    pins = 8'h01; wr = 1'b1; addr = REG_CLEAR; wdata = 8'h01;
    @(negedge clk);
    wr = 1'b0;
    rreg(REG_RAW, v); check("R8 set beats clear", v, 8'h01);
    clean();
  endtask

  task automatic t_mode();
    logic [7:0] v;
    wreg(REG_POL, 8'h10);
    drive(8'h10);
    drive(8'h00);
    wreg(REG_SENSE, 8'h10);
    rreg(REG_RAW, v); check("R9 level view", v, 8'h00);
    wreg(REG_SENSE, 8'h00);
    rreg(REG_RAW, v); check("R9 latch kept", v, 8'h10);
    wreg(REG_CLEAR, 8'h10);
    wreg(REG_SENSE, 8'h10);
    drive(8'h10);
    drive(8'h00);
    wreg(REG_SENSE, 8'h00);
    rreg(REG_RAW, v); check("R9 no latch in level", v, 8'h00);
    clean();
  endtask

  task automatic t_mask();
    logic [7:0] v;
    wreg(REG_POL, 8'h05);
    drive(8'h05);
    wreg(REG_EN, 8'h01);
    rreg(REG_MASKED, v); check("R10 masked", v, 8'h01);
    check("R11 irq set", {7'd0, irq}, 8'h01);
    wreg(REG_EN, 8'h02);
    rreg(REG_MASKED, v); check("R10 masked none", v, 8'h00);
    check("R11 irq clear", {7'd0, irq}, 8'h00);
    wreg(REG_RAW, 8'h00);
    wreg(REG_MASKED, 8'hFF);
    rreg(REG_RAW, v); check("R10 raw read-only", v, 8'h05);
    rreg(REG_EN, v); check("R10 enable untouched", v, 8'h02);
    clean();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_clear();
    t_priority();
    t_mode();
    t_mask();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule